// File: doc/BRIEF.md
# Software Write-Protection Sequence Gate

This block sits on the write path of a byte-wide nonvolatile array and decides, load by load, whether a byte may be handed on to the programming logic. It watches the chip-select, write-strobe and output-enable lines together with the address and data buses. It turns each valid write strobe into one "load", and runs those loads through a command matcher. The matcher tracks one global protection mode that covers the whole array.

While protection is off, ordinary loads pass straight through. A three-load unlock prefix switches protection on and lets the next load through. From then on, that same prefix has to come before every data write. A six-load command clears protection again. A load that arrives while protection is on, and without the prefix, is dropped. The block then refuses all traffic for a programmable lockout period. Hardware inhibit lines and a minimum strobe width filter out glitches and unsafe conditions before any load reaches the matcher.

Top module: `sw_protect_gate`

## Requirements
- R1: After reset, `prot_on`, `busy` and `wr_permit` are all 0, and the matcher waits for the start of a sequence.
- R2: A load is taken when the strobe (`ce_n` and `we_n` both low) ends. With protection off, an ordinary load raises `wr_permit` for exactly one cycle, two cycles after the strobe ends, carrying the strobe's address on `wr_addr` and its data on `wr_data`.
- R3: A strobe that is active for fewer than `MIN_PULSE` consecutive clock cycles produces no load: there is no permit and no change of state.
- R4: A strobe produces no load if, during any cycle of it, `oe_n` is low or `supply_low` is high. With `ce_n` high there is no strobe at all.
- R5: The loads AA at 5555h, then 55 at 2AAAh, then A0 at 5555h set `prot_on` to 1. The next load is then permitted. None of the three command loads is itself permitted.
- R6: With protection on, a load that does not follow the prefix is not permitted. `busy` rises in the same cycle that a permit would have appeared, and stays high for exactly `LOCK_CYCLES` cycles.
- R7: While `busy` is high, every load is ignored. There is no permit, no matcher progress and no change of protection.
- R8: With protection on, prefix plus data gives one permitted write, and `prot_on` stays 1. The following data load again needs the prefix.
- R9: The six loads AA/5555h, 55/2AAAh, 80/5555h, AA/5555h, 55/2AAAh, 20/5555h clear `prot_on`. None of these six loads is permitted.
- R10: A load that breaks a sequence in progress returns the matcher to idle without changing protection. The breaking load is then judged as a fresh load: it starts a new sequence if it is AA/5555h; otherwise it is permitted when protection is off and rejected when protection is on.
- R11: Command matching compares only address bits 14:0. Higher address bits are ignored, so protection state is global across the array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output enable, active low; low inhibits writes |
| supply_low | input | 1 | Supply below write threshold; high inhibits writes |
| addr | input | ADDR_W | Byte address of the load |
| din | input | 8 | Data byte of the load |
| wr_permit | output | 1 | One-cycle pulse: the load may be programmed |
| wr_addr | output | ADDR_W | Address accompanying `wr_permit` |
| wr_data | output | 8 | Data accompanying `wr_permit` |
| prot_on | output | 1 | Global protection mode |
| busy | output | 1 | Lockout after a rejected write |

## Verification
The bench goes after the following corner cases:

- **Broken sequences.** A design that forgot the breaking load would swallow a write. One that kept the partial match would unlock on a later stray byte.
- **Strobes exactly one cycle short of the minimum width.** An off-by-one here would let glitches write.
- **Inhibit lines asserted for part of a strobe.** A design that sampled only the last cycle would let those strobes write.
- **Loads arriving during the lockout.** A design that still advanced the matcher there would let a prefix sent during lockout unlock the next write.
- **The exact length of the lockout window, and mirrored command addresses.** A miscounted timer shows up as `busy` falling one cycle early or late. Decoding the full address would leave protection stuck on.

// File: rtl/unlk_pkg.sv
package unlk_pkg;

    localparam int CMD_AW = 15;

    localparam logic [CMD_AW-1:0] ADR_LO = 15'h5555;
    localparam logic [CMD_AW-1:0] ADR_HI = 15'h2AAA;

    localparam logic [7:0] BYTE_FIRST  = 8'hAA;
    localparam logic [7:0] BYTE_SECOND = 8'h55;
    localparam logic [7:0] BYTE_ARM    = 8'hA0;
    localparam logic [7:0] BYTE_EXT    = 8'h80;
    localparam logic [7:0] BYTE_CLEAR  = 8'h20;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_U1,
        SQ_U2,
        SQ_ARMED,
        SQ_D3,
        SQ_D4,
        SQ_D5
    } seq_e;

    typedef struct packed {
        logic permit;
        logic reject;
        logic prot_nx;
        seq_e nx;
    } seq_dec_t;

    function automatic logic cmd_hit(input logic [CMD_AW-1:0] a, input logic [7:0] d,
                                     input logic [CMD_AW-1:0] ea, input logic [7:0] ed);
        return (a == ea) && (d == ed);
    endfunction

    // Decision for a load judged with no sequence in progress.
    function automatic seq_dec_t fresh_load(input logic starts_seq, input logic prot);
        seq_dec_t r;
        r.nx      = starts_seq ? SQ_U1 : SQ_IDLE;
        r.permit  = !starts_seq && !prot;
        r.reject  = !starts_seq && prot;
        r.prot_nx = prot;
        return r;
    endfunction

endpackage

// File: rtl/strobe_filter.sv
module strobe_filter #(
    parameter int ADDR_W    = 17,
    parameter int MIN_PULSE = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic              supply_low,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        din,
    output logic              ld_vld,
    output logic [ADDR_W-1:0] ld_addr,
    output logic [7:0]        ld_data
);
    localparam int CW = $clog2(MIN_PULSE + 1);
    localparam logic [CW-1:0] CMAX = CW'(MIN_PULSE);

    logic              strobe;
    logic              inhibit;
    logic [CW-1:0]     width_q;
    logic              spoiled_q;
    logic [ADDR_W-1:0] cap_addr;
    logic [7:0]        cap_data;

    assign strobe  = !ce_n && !we_n;
    assign inhibit = !oe_n || supply_low;

    always_ff @(posedge clk) begin
        if (rst) begin
            width_q   <= '0;
            spoiled_q <= 1'b0;
            ld_vld    <= 1'b0;
            cap_addr  <= '0;
            cap_data  <= '0;
            ld_addr   <= '0;
            ld_data   <= '0;
        end else begin
            ld_vld <= 1'b0;
            if (strobe) begin
                if (width_q != CMAX) width_q <= width_q + 1'b1;
                spoiled_q <= spoiled_q || inhibit;
                cap_addr  <= addr;
                cap_data  <= din;
            end else if (width_q != '0) begin
                ld_vld    <= (width_q == CMAX) && !spoiled_q;
                ld_addr   <= cap_addr;
                ld_data   <= cap_data;
                width_q   <= '0;
                spoiled_q <= 1'b0;
            end
        end
    end

    // R3
    ld_after_end_chk: assert property (@(posedge clk) disable iff (rst)
        ld_vld |-> !$past(strobe));

endmodule

// File: rtl/lock_timer.sv
module lock_timer #(
    parameter int LOCK_CYCLES = 30000
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy
);
    localparam int LW = $clog2(LOCK_CYCLES + 1);

    logic [LW-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            left_q <= '0;
        end else if (start) begin
            left_q <= LW'(LOCK_CYCLES);
        end else if (left_q != '0) begin
            left_q <= left_q - 1'b1;
        end
    end

    assign busy = (left_q != '0);

    // R6
    lock_entry_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start));

endmodule

// File: rtl/seq_matcher.sv
module seq_matcher
    import unlk_pkg::*;
#(
    parameter int ADDR_W = 17
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_vld,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [7:0]        ld_data,
    input  logic              busy,
    output logic              permit,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic              prot_on,
    output logic              reject
);
    seq_e             st_q;
    seq_dec_t         dec;
    logic             brk;
    logic [CMD_AW-1:0] ca;
    logic             h_first, h_second, h_arm, h_ext, h_clear;

    assign ca       = ld_addr[CMD_AW-1:0];
    assign h_first  = cmd_hit(ca, ld_data, ADR_LO, BYTE_FIRST);
    assign h_second = cmd_hit(ca, ld_data, ADR_HI, BYTE_SECOND);
    assign h_arm    = cmd_hit(ca, ld_data, ADR_LO, BYTE_ARM);
    assign h_ext    = cmd_hit(ca, ld_data, ADR_LO, BYTE_EXT);
    assign h_clear  = cmd_hit(ca, ld_data, ADR_LO, BYTE_CLEAR);

    always_comb begin
        dec.permit  = 1'b0;
        dec.reject  = 1'b0;
        dec.prot_nx = prot_on;
        dec.nx      = st_q;
        brk         = 1'b0;
        if (ld_vld && !busy) begin
            case (st_q)
                SQ_U1:    if (h_second) dec.nx = SQ_U2; else brk = 1'b1;
                SQ_U2: begin
                    if (h_arm) begin
                        dec.nx      = SQ_ARMED;
                        dec.prot_nx = 1'b1;
                    end else if (h_ext) begin
                        dec.nx = SQ_D3;
                    end else begin
                        brk = 1'b1;
                    end
                end
                SQ_ARMED: begin
                    dec.permit = 1'b1;
                    dec.nx     = SQ_IDLE;
                end
                SQ_D3:    if (h_first)  dec.nx = SQ_D4; else brk = 1'b1;
                SQ_D4:    if (h_second) dec.nx = SQ_D5; else brk = 1'b1;
                SQ_D5: begin
                    if (h_clear) begin
                        dec.nx      = SQ_IDLE;
                        dec.prot_nx = 1'b0;
                    end else begin
                        brk = 1'b1;
                    end
                end
                default:  brk = 1'b1;
            endcase
            if (brk) dec = fresh_load(h_first, prot_on);
        end
    end

    assign reject = dec.reject;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= SQ_IDLE;
            prot_on <= 1'b0;
            permit  <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            st_q    <= dec.nx;
            prot_on <= dec.prot_nx;
            permit  <= dec.permit;
            if (dec.permit) begin
                wr_addr <= ld_addr;
                wr_data <= ld_data;
            end
        end
    end

    // R7
    busy_blocks_chk: assert property (@(posedge clk) disable iff (rst)
        busy |=> !permit);

    // R9
    prot_by_load_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(prot_on) |-> $past(ld_vld));

endmodule

// File: rtl/sw_protect_gate.sv
module sw_protect_gate #(
    parameter int ADDR_W      = 17,
    parameter int MIN_PULSE   = 2,
    parameter int LOCK_CYCLES = 30000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic              supply_low,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        din,
    output logic              wr_permit,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic              prot_on,
    output logic              busy
);
    logic              ld_vld;
    logic [ADDR_W-1:0] ld_addr;
    logic [7:0]        ld_data;
    logic              reject;

    strobe_filter #(.ADDR_W(ADDR_W), .MIN_PULSE(MIN_PULSE)) i_filter (
        .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .supply_low(supply_low), .addr(addr), .din(din),
        .ld_vld(ld_vld), .ld_addr(ld_addr), .ld_data(ld_data)
    );

    seq_matcher #(.ADDR_W(ADDR_W)) i_matcher (
        .clk(clk), .rst(rst), .ld_vld(ld_vld), .ld_addr(ld_addr),
        .ld_data(ld_data), .busy(busy), .permit(wr_permit),
        .wr_addr(wr_addr), .wr_data(wr_data), .prot_on(prot_on),
        .reject(reject)
    );

    lock_timer #(.LOCK_CYCLES(LOCK_CYCLES)) i_lock (
        .clk(clk), .rst(rst), .start(reject), .busy(busy)
    );

    // R2
    permit_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        wr_permit |=> !wr_permit);

    // R6
    lock_from_load_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(ld_vld));

endmodule

// File: tb/test_sw_protect_gate.sv
module test_sw_protect_gate;
    localparam int AW   = 17;
    localparam int MINP = 2;
    localparam int LOCK = 40;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, supply_low = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [7:0] din = '0;
    logic wr_permit, prot_on, busy;
    logic [AW-1:0] wr_addr;
    logic [7:0] wr_data;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    // model: 0 idle,1 u1,2 u2,3 armed,4 d3,5 d4,6 d5
    int ms = 0;
    bit mp = 0;

    always #5 clk = ~clk;

    sw_protect_gate #(.ADDR_W(AW), .MIN_PULSE(MINP), .LOCK_CYCLES(LOCK)) i_sw_protect_gate (
        .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .supply_low(supply_low), .addr(addr), .din(din),
        .wr_permit(wr_permit), .wr_addr(wr_addr), .wr_data(wr_data),
        .prot_on(prot_on), .busy(busy)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic bit is_cmd(input logic [AW-1:0] a, input logic [7:0] d,
                                  input logic [14:0] ea, input logic [7:0] ed);
        return (a[14:0] == ea) && (d == ed);
    endfunction

    // Expected outcome of one accepted load, from the requirements.
    task automatic model(input logic [AW-1:0] a, input logic [7:0] d,
                         output bit perm, output bit rej);
        bit brk = 0;
        bit aa = is_cmd(a, d, 15'h5555, 8'hAA);
        bit s55 = is_cmd(a, d, 15'h2AAA, 8'h55);
        perm = 0; rej = 0;
        case (ms)
            1: if (s55) ms = 2; else brk = 1;
            2: if (is_cmd(a, d, 15'h5555, 8'hA0)) begin ms = 3; mp = 1; end
               else if (is_cmd(a, d, 15'h5555, 8'h80)) ms = 4;
               else brk = 1;
            3: begin perm = 1; ms = 0; end
            4: if (aa) ms = 5; else brk = 1;
            5: if (s55) ms = 6; else brk = 1;
            6: if (is_cmd(a, d, 15'h5555, 8'h20)) begin mp = 0; ms = 0; end else brk = 1;
            default: brk = 1;
        endcase
        if (brk) begin
            if (aa) ms = 1;
            else begin ms = 0; if (mp) rej = 1; else perm = 1; end
        end
    endtask

    // inh: 0 none, 1 oe_n low, 2 supply_low, 3 ce_n held high
    task automatic drive(input logic [AW-1:0] a, input logic [7:0] d, input int w, input int inh);
        @(negedge clk);
        addr = a; din = d;
        we_n = 1'b0;
        ce_n = (inh == 3);
        oe_n = (inh != 1);
        supply_low = (inh == 2);
        repeat (w) @(negedge clk);
        we_n = 1'b1; ce_n = 1'b1; oe_n = 1'b1; supply_low = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic wait_lock(input string req);
        chk(busy === 1'b1, req, "busy at start", busy, 1);
        repeat (LOCK - 1) @(negedge clk);
        chk(busy === 1'b1, req, "busy last cycle", busy, 1);
        @(negedge clk);
        chk(busy === 1'b0, req, "busy released", busy, 0);
    endtask

    // Accepted-or-not load with full checking against the model.
    task automatic load(input logic [AW-1:0] a, input logic [7:0] d, input int w,
                        input int inh, input string req);
        bit perm = 0, rej = 0;
        drive(a, d, w, inh);
        if (w >= MINP && inh == 0) model(a, d, perm, rej);
        chk(wr_permit === perm, req, "wr_permit", wr_permit, perm);
        if (perm) begin
            chk(wr_addr === a, req, "wr_addr", wr_addr, a);
            chk(wr_data === d, req, "wr_data", wr_data, d);
        end
        chk(prot_on === mp, req, "prot_on", prot_on, mp);
        if (rej) wait_lock(req);
        else chk(busy === 1'b0, req, "busy idle", busy, 0);
    endtask

    task automatic lockbody(input logic [AW-1:0] a, input logic [7:0] d);
        drive(a, d, MINP, 0);
        chk(wr_permit === 1'b0, "R7", "permit during lockout", wr_permit, 0);
        chk(busy === 1'b1, "R7", "still busy", busy, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        chk(prot_on === 1'b0, "R1", "prot_on after reset", prot_on, 0);
        chk(busy === 1'b0, "R1", "busy after reset", busy, 0);
        chk(wr_permit === 1'b0, "R1", "wr_permit after reset", wr_permit, 0);

        load(17'h01234, 8'h3C, MINP, 0, "R2");
        load(17'h10007, 8'hE1, MINP + 3, 0, "R2");
        load(17'h00042, 8'h99, MINP - 1, 0, "R3");
        load(17'h00043, 8'h98, MINP, 1, "R4");
        load(17'h00044, 8'h97, MINP, 2, "R4");
        load(17'h00045, 8'h96, MINP, 3, "R4");

        // R10: broken sequence while unprotected; breaking load is written
        load(17'h05555, 8'hAA, MINP, 0, "R10");
        load(17'h02AAA, 8'h55, MINP, 0, "R10");
        load(17'h00100, 8'h12, MINP, 0, "R10");

        // R5: enable, then data write
        load(17'h05555, 8'hAA, MINP, 0, "R5");
        load(17'h02AAA, 8'h55, MINP, 0, "R5");
        load(17'h05555, 8'hA0, MINP, 0, "R5");
        load(17'h00200, 8'h5A, MINP, 0, "R5");

        // R6: write without prefix is rejected with lockout
        load(17'h00300, 8'h11, MINP, 0, "R6");

        // R8: prefix plus write, then prefix needed again
        load(17'h05555, 8'hAA, MINP, 0, "R8");
        load(17'h02AAA, 8'h55, MINP, 0, "R8");
        load(17'h05555, 8'hA0, MINP, 0, "R8");
        load(17'h00301, 8'h22, MINP, 0, "R8");
        load(17'h00302, 8'h33, MINP, 0, "R8");

        // R7: prefix sent during lockout is ignored
        drive(17'h00400, 8'h44, MINP, 0);
        chk(busy === 1'b1, "R7", "lockout started", busy, 1);
        lockbody(17'h05555, 8'hAA);
        lockbody(17'h02AAA, 8'h55);
        lockbody(17'h05555, 8'hA0);
        for (int i = 0; i < 100 && busy; i++) @(negedge clk);
        ms = 0;
        load(17'h00401, 8'h45, MINP, 0, "R7");

        // R10: broken sequence while protected is rejected
        load(17'h05555, 8'hAA, MINP, 0, "R10");
        load(17'h00555, 8'h77, MINP, 0, "R10");

        // R9 with R11 mirrored addresses: disable
        load(17'h15555, 8'hAA, MINP, 0, "R11");
        load(17'h12AAA, 8'h55, MINP, 0, "R11");
        load(17'h05555, 8'h80, MINP, 0, "R9");
        load(17'h05555, 8'hAA, MINP, 0, "R9");
        load(17'h02AAA, 8'h55, MINP, 0, "R9");
        load(17'h05555, 8'h20, MINP, 0, "R9");
        load(17'h00500, 8'h66, MINP, 0, "R9");

        // Random phase biased toward command bytes
        for (int n = 0; n < 400; n++) begin
            logic [AW-1:0] a;
            logic [7:0] d;
            int w, inh;
            a = AW'($urandom);
            d = 8'($urandom);
            case ($urandom % 8)
                0, 1: begin a[14:0] = 15'h5555; d = 8'hAA; end
                2, 3: begin a[14:0] = 15'h2AAA; d = 8'h55; end
                4:    begin a[14:0] = 15'h5555; d = 8'hA0; end
                5:    begin a[14:0] = 15'h5555; d = (($urandom % 2) != 0) ? 8'h80 : 8'h20; end
                default: ;
            endcase
            w = 1 + int'($urandom % 4);
            inh = (($urandom % 8) == 0) ? 1 + int'($urandom % 3) : 0;
            load(a, d, w, inh, "R10");
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule